// File: doc/BRIEF.md
# Framebuffer Scanout Fetch Sequencer

The block walks one frame of pixel data in memory and turns it into a stream of burst read requests. A pulse on `frame_start` captures the settings: the frame origin address, the bytes to fetch per line, the byte step from one line start to the next, the line count (stored less one) and the bus limits. Each line is cut into bursts no longer than the configured beat count. The last burst of a line carries whatever remains. The block then jumps to the next line start. When the final line has been requested it goes idle and stays idle until the next frame pulse.

The read data lands in a pixel FIFO that sits outside this block. The block follows how full that FIFO is from two strobes: one for each beat written into it and one for each pixel the display takes from it. It also counts the beats it has requested that have not yet arrived. A new request goes out only when two conditions both hold. The number of unfinished bursts must be below the programmed limit, and the FIFO must have room for every beat already promised plus the new burst. When the display asks for a pixel during active video and the FIFO is empty, an underrun pulse is raised.

Top module: `scan_fetch_top`

## Requirements
- R1: After reset `req_valid`, `frame_busy` and `underrun` are all 0.
- R2: A `frame_start` pulse captures `cfg_base` and the other settings. The first request of the frame targets `cfg_base`, and line n starts at `cfg_base + n*cfg_pitch`. A pulse that arrives while a frame is running abandons that frame and restarts from the newly captured base.
- R3: A line holds ceil(`cfg_line_bytes`/8) beats of 8 bytes each, and a line of 0 bytes holds 1 beat. The line is issued as bursts of the burst length, with a shorter final burst, and each burst address is the previous one plus 8 times its beat count.
- R4: A `cfg_burst_len` of 0 is used as 1, and any value above 16 is used as 16.
- R5: A frame holds `cfg_lines_m1`+1 lines, capped at MAX_LINES (2048 by default).
- R6: The number of accepted bursts whose last beat (`fill_last`) has not yet arrived never exceeds the limit. A `cfg_max_out` of 0 is used as 1, and any value above 8 is used as 8. A burst accepted in the same cycle that another burst finishes leaves the count unchanged.
- R7: A burst is offered only when the FIFO depth (64 beats) minus the FIFO level minus the beats in flight is at least the burst length.
- R8: After the final burst of the last line is accepted, `frame_busy` drops, and no request is offered until the next `frame_start`.
- R9: `underrun` is high in the cycle after any cycle with `pix_pop` and `pix_active` high while the FIFO level is 0. This includes a cycle in which a beat is written into the empty FIFO. A pop while `pix_active` is low, or while the FIFO level is above 0, raises no underrun, and a pop on an empty FIFO leaves the level at 0.
- R10: While `req_valid` is high and `req_ready` is low, with no `frame_start`, the request stays offered with the same address and beat count in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| frame_start | input | 1 | One-cycle pulse that starts a frame |
| cfg_base | input | 32 | Byte address of the first pixel |
| cfg_line_bytes | input | 16 | Bytes fetched per line |
| cfg_pitch | input | 16 | Byte step between line starts |
| cfg_lines_m1 | input | 12 | Line count minus one |
| cfg_burst_len | input | 5 | Maximum beats per burst |
| cfg_max_out | input | 4 | Maximum unfinished bursts |
| req_valid | output | 1 | Read request offered |
| req_ready | input | 1 | Memory side accepts the request |
| req_addr | output | 32 | Byte address of the burst |
| req_beats | output | 5 | Beats in the burst |
| fill_beat | input | 1 | One beat written into the pixel FIFO |
| fill_last | input | 1 | That beat ends its burst |
| pix_pop | input | 1 | Display takes one entry from the FIFO |
| pix_active | input | 1 | Display is in active video |
| underrun | output | 1 | Pop found the FIFO empty in active video |
| frame_busy | output | 1 | Frame fetch in progress |

## Verification
Two groups of events can land on the same edge. The first is a burst acceptance together with the last beat of an earlier burst. The bench provokes this by programming single-beat bursts with a limit of two and a responder that returns each beat one cycle after acceptance. It records every cycle where a handshake coincides with `fill_last`, and it then judges that the outstanding count it tracks never exceeds the limit and that the full request list still comes out in order. The second is a beat arriving on an empty FIFO while the display pops. The bench's own level model predicts that this still raises `underrun`, and the bench compares the flag with that prediction in every cycle.

// File: rtl/scan_fetch_pkg.sv
package scan_fetch_pkg;

  // Beats needed for a byte count; a zero-byte line still takes one beat.
  function automatic int unsigned f_line_beats(input int unsigned nbytes,
                                               input int unsigned beat_shift);
    int unsigned n;
    n = (nbytes + (32'd1 << beat_shift) - 32'd1) >> beat_shift;
    return (n == 0) ? 32'd1 : n;
  endfunction

  // Saturate a setting into [lo, hi].
  function automatic int unsigned f_clamp(input int unsigned v,
                                          input int unsigned lo,
                                          input int unsigned hi);
    if (v < lo) return lo;
    if (v > hi) return hi;
    return v;
  endfunction

  // Beats of the next burst: the remainder or the burst size, whichever is smaller.
  function automatic int unsigned f_next_burst(input int unsigned remain,
                                               input int unsigned blen);
    return (remain < blen) ? remain : blen;
  endfunction

endpackage

// File: rtl/scan_fetch_walker.sv
module scan_fetch_walker
  import scan_fetch_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int BYTES_W    = 16,
  parameter int LINE_W     = 12,
  parameter int MAX_LINES  = 2048,
  parameter int BEAT_BYTES = 8,
  parameter int MAX_BURST  = 16,
  localparam int BURST_W   = $clog2(MAX_BURST + 1),
  localparam int BEAT_SH   = $clog2(BEAT_BYTES)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               frame_start,
  input  logic [ADDR_W-1:0]  cfg_base,
  input  logic [BYTES_W-1:0] cfg_line_bytes,
  input  logic [BYTES_W-1:0] cfg_pitch,
  input  logic [LINE_W-1:0]  cfg_lines_m1,
  input  logic [BURST_W-1:0] cfg_burst_len,
  input  logic               grant,
  output logic               busy,
  output logic [ADDR_W-1:0]  cur_addr,
  output logic [BURST_W-1:0] cur_beats,
  output logic               ev_line_end,
  output logic               ev_frame_end
);

  logic [ADDR_W-1:0]  line_addr;
  logic [BYTES_W-1:0] beats_left;
  logic [LINE_W-1:0]  line_idx;
  logic [BYTES_W-1:0] sh_line_beats;
  logic [BYTES_W-1:0] sh_pitch;
  logic [LINE_W-1:0]  sh_lines_m1;
  logic [BURST_W-1:0] sh_burst;
  logic [ADDR_W-1:0]  next_line_addr;
  logic               line_last;

  always_comb begin
    cur_beats      = BURST_W'(f_next_burst(32'(beats_left), 32'(sh_burst)));
    line_last      = (beats_left == BYTES_W'(cur_beats));
    next_line_addr = line_addr + ADDR_W'(sh_pitch);
    ev_line_end    = grant && line_last;
    ev_frame_end   = ev_line_end && (line_idx == sh_lines_m1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy          <= 1'b0;
      cur_addr      <= '0;
      line_addr     <= '0;
      beats_left    <= '0;
      line_idx      <= '0;
      sh_line_beats <= '0;
      sh_pitch      <= '0;
      sh_lines_m1   <= '0;
      sh_burst      <= BURST_W'(1);
    end else if (frame_start) begin
      busy          <= 1'b1;
      cur_addr      <= cfg_base;
      line_addr     <= cfg_base;
      line_idx      <= '0;
      beats_left    <= BYTES_W'(f_line_beats(32'(cfg_line_bytes), BEAT_SH));
      sh_line_beats <= BYTES_W'(f_line_beats(32'(cfg_line_bytes), BEAT_SH));
      sh_pitch      <= cfg_pitch;
      sh_lines_m1   <= LINE_W'(f_clamp(32'(cfg_lines_m1), 0, MAX_LINES - 1));
      sh_burst      <= BURST_W'(f_clamp(32'(cfg_burst_len), 1, MAX_BURST));
    end else if (grant) begin
      if (ev_frame_end) begin
        busy <= 1'b0;
      end else if (line_last) begin
        line_idx   <= line_idx + LINE_W'(1);
        line_addr  <= next_line_addr;
        cur_addr   <= next_line_addr;
        beats_left <= sh_line_beats;
      end else begin
        cur_addr   <= cur_addr + (ADDR_W'(cur_beats) << BEAT_SH);
        beats_left <= beats_left - BYTES_W'(cur_beats);
      end
    end
  end

  // R2: a frame pulse points the walker at the captured base
  p_base_load_r2: assert property (@(posedge clk) disable iff (!rst_n)
    frame_start |=> (busy && cur_addr == $past(cfg_base)));

  // R3 and R4: an offered burst is never empty and never above the cap
  p_burst_bounds_r4: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (cur_beats != 0 && cur_beats <= BURST_W'(MAX_BURST)));

  // R5: the line index stays under the maximum line count
  p_line_cap_r5: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (32'(line_idx) < MAX_LINES));

  // R8: the end of the last line leaves the walker idle
  p_frame_end_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_frame_end && !frame_start) |=> !busy);

endmodule

// File: rtl/scan_fetch_outstanding.sv
module scan_fetch_outstanding
  import scan_fetch_pkg::*;
#(
  parameter int MAX_OUT = 8,
  localparam int OUT_W  = $clog2(MAX_OUT + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             frame_start,
  input  logic [OUT_W-1:0] cfg_max_out,
  input  logic             grant,
  input  logic             fill_last,
  output logic             slot_ok
);

  logic [OUT_W-1:0] out_cnt;
  logic [OUT_W-1:0] out_lim;
  logic             retire;

  assign retire  = fill_last && (out_cnt != 0);
  assign slot_ok = (out_cnt < out_lim);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_cnt <= '0;
      out_lim <= OUT_W'(1);
    end else begin
      out_cnt <= out_cnt + OUT_W'(grant) - OUT_W'(retire);
      if (frame_start)
        out_lim <= OUT_W'(f_clamp(32'(cfg_max_out), 1, MAX_OUT));
    end
  end

  // R6: unfinished bursts never exceed the limit
  p_out_limit_r6: assert property (@(posedge clk) disable iff (!rst_n)
    out_cnt <= OUT_W'(MAX_OUT));

  // R6: acceptance and retirement on one edge cancel
  p_out_cancel_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (grant && retire) |=> (out_cnt == $past(out_cnt)));

endmodule

// File: rtl/scan_fetch_fifo_track.sv
module scan_fetch_fifo_track #(
  parameter int FIFO_DEPTH = 64,
  parameter int MAX_BURST  = 16,
  localparam int LVL_W     = $clog2(FIFO_DEPTH + 1),
  localparam int BURST_W   = $clog2(MAX_BURST + 1)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               grant,
  input  logic [BURST_W-1:0] grant_beats,
  input  logic [BURST_W-1:0] want_beats,
  input  logic               fill_beat,
  input  logic               pix_pop,
  input  logic               pix_active,
  output logic               room_ok,
  output logic               underrun
);

  logic [LVL_W-1:0] level;
  logic [LVL_W-1:0] inflight;
  logic [LVL_W:0]   used;
  logic [LVL_W:0]   spare;
  logic             pop_ok;
  logic             arrive;

  always_comb begin
    used    = (LVL_W + 1)'(level) + (LVL_W + 1)'(inflight);
    spare   = (LVL_W + 1)'(FIFO_DEPTH) - used;
    room_ok = spare >= (LVL_W + 1)'(want_beats);
    pop_ok  = pix_pop && (level != 0);
    arrive  = fill_beat && (inflight != 0);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      level    <= '0;
      inflight <= '0;
      underrun <= 1'b0;
    end else begin
      level    <= level + LVL_W'(arrive) - LVL_W'(pop_ok);
      inflight <= inflight + (grant ? LVL_W'(grant_beats) : '0) - LVL_W'(arrive);
      underrun <= pix_pop && pix_active && (level == 0);
    end
  end

  // R7: promised plus stored beats never exceed the FIFO
  p_no_overflow_r7: assert property (@(posedge clk) disable iff (!rst_n)
    used <= (LVL_W + 1)'(FIFO_DEPTH));

  // R9: an underrun always follows an active-video pop
  p_under_cause_r9: assert property (@(posedge clk) disable iff (!rst_n)
    underrun |-> $past(pix_pop && pix_active));

endmodule

// File: rtl/scan_fetch_top.sv
module scan_fetch_top #(
  parameter int ADDR_W     = 32,
  parameter int BYTES_W    = 16,
  parameter int LINE_W     = 12,
  parameter int MAX_LINES  = 2048,
  parameter int BEAT_BYTES = 8,
  parameter int MAX_BURST  = 16,
  parameter int MAX_OUT    = 8,
  parameter int FIFO_DEPTH = 64,
  localparam int BURST_W   = $clog2(MAX_BURST + 1),
  localparam int OUT_W     = $clog2(MAX_OUT + 1)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               frame_start,
  input  logic [ADDR_W-1:0]  cfg_base,
  input  logic [BYTES_W-1:0] cfg_line_bytes,
  input  logic [BYTES_W-1:0] cfg_pitch,
  input  logic [LINE_W-1:0]  cfg_lines_m1,
  input  logic [BURST_W-1:0] cfg_burst_len,
  input  logic [OUT_W-1:0]   cfg_max_out,
  output logic               req_valid,
  input  logic               req_ready,
  output logic [ADDR_W-1:0]  req_addr,
  output logic [BURST_W-1:0] req_beats,
  input  logic               fill_beat,
  input  logic               fill_last,
  input  logic               pix_pop,
  input  logic               pix_active,
  output logic               underrun,
  output logic               frame_busy
);

  logic grant;
  logic slot_ok;
  logic room_ok;
  logic ev_line_end;
  logic ev_frame_end;

  assign req_valid = frame_busy && slot_ok && room_ok;
  assign grant     = req_valid && req_ready;

  scan_fetch_walker #(
    .ADDR_W(ADDR_W), .BYTES_W(BYTES_W), .LINE_W(LINE_W),
    .MAX_LINES(MAX_LINES), .BEAT_BYTES(BEAT_BYTES), .MAX_BURST(MAX_BURST)
  ) u_walker (
    .clk(clk), .rst_n(rst_n), .frame_start(frame_start),
    .cfg_base(cfg_base), .cfg_line_bytes(cfg_line_bytes), .cfg_pitch(cfg_pitch),
    .cfg_lines_m1(cfg_lines_m1), .cfg_burst_len(cfg_burst_len),
    .grant(grant), .busy(frame_busy), .cur_addr(req_addr), .cur_beats(req_beats),
    .ev_line_end(ev_line_end), .ev_frame_end(ev_frame_end)
  );

  scan_fetch_outstanding #(.MAX_OUT(MAX_OUT)) u_out (
    .clk(clk), .rst_n(rst_n), .frame_start(frame_start), .cfg_max_out(cfg_max_out),
    .grant(grant), .fill_last(fill_last), .slot_ok(slot_ok)
  );

  scan_fetch_fifo_track #(.FIFO_DEPTH(FIFO_DEPTH), .MAX_BURST(MAX_BURST)) u_fifo (
    .clk(clk), .rst_n(rst_n), .grant(grant), .grant_beats(req_beats),
    .want_beats(req_beats), .fill_beat(fill_beat), .pix_pop(pix_pop),
    .pix_active(pix_active), .room_ok(room_ok), .underrun(underrun)
  );

  // R10: a stalled request holds still
  p_req_stable_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_ready && !frame_start) |=>
      (req_valid && $stable(req_addr) && $stable(req_beats)));

  // R3: a burst that ends a line is never longer than one burst
  p_line_end_len_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ev_line_end |-> (req_beats <= BURST_W'(MAX_BURST)));

endmodule

// File: tb/scan_fetch_top_tb.sv
`timescale 1ns/1ps
module scan_fetch_top_tb;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        frame_start = 1'b0;
  logic [31:0] cfg_base = '0;
  logic [15:0] cfg_line_bytes = '0;
  logic [15:0] cfg_pitch = '0;
  logic [11:0] cfg_lines_m1 = '0;
  logic [4:0]  cfg_burst_len = 5'd16;
  logic [3:0]  cfg_max_out = 4'd4;
  logic        req_valid;
  logic        req_ready = 1'b1;
  logic [31:0] req_addr;
  logic [4:0]  req_beats;
  logic        fill_beat = 1'b0;
  logic        fill_last = 1'b0;
  logic        pix_pop = 1'b0;
  logic        pix_active = 1'b0;
  logic        underrun;
  logic        frame_busy;

  always #2.5 clk = ~clk;

  scan_fetch_top u_dut (
    .clk(clk), .rst_n(rst_n), .frame_start(frame_start), .cfg_base(cfg_base),
    .cfg_line_bytes(cfg_line_bytes), .cfg_pitch(cfg_pitch), .cfg_lines_m1(cfg_lines_m1),
    .cfg_burst_len(cfg_burst_len), .cfg_max_out(cfg_max_out), .req_valid(req_valid),
    .req_ready(req_ready), .req_addr(req_addr), .req_beats(req_beats),
    .fill_beat(fill_beat), .fill_last(fill_last), .pix_pop(pix_pop),
    .pix_active(pix_active), .underrun(underrun), .frame_busy(frame_busy)
  );

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  // responder / monitor state
  bit resp_on = 1'b1, pop_on = 1'b1, act_on = 1'b0;
  int pq[$];
  logic [31:0] log_addr[0:4095];
  int log_beats[0:4095];
  int log_n = 0;
  int out_m = 0, out_peak = 0, coinc = 0, back2back = 0;
  int lvl = 0, under_bad = 0, under_seen = 0;
  bit exp_under = 1'b0, prev_hs = 1'b0;

  task automatic check(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  initial begin
    forever begin
      @(negedge clk); #1;
      if (resp_on && pq.size() > 0) begin
        fill_beat = 1'b1;
        fill_last = (pq[0] == 1);
        if (pq[0] == 1) void'(pq.pop_front());
        else pq[0] = pq[0] - 1;
      end else begin
        fill_beat = 1'b0;
        fill_last = 1'b0;
      end
      pix_pop = pop_on;
      pix_active = act_on;
      if (rst_n) begin
        if (underrun !== exp_under) under_bad++;
        if (underrun === 1'b1) under_seen++;
      end
      exp_under = pix_pop && pix_active && (lvl == 0);
      if (req_valid === 1'b1 && req_ready) begin
        if (log_n < 4096) begin
          log_addr[log_n] = req_addr;
          log_beats[log_n] = int'(req_beats);
        end
        log_n++;
        pq.push_back(int'(req_beats));
        out_m++;
        if (fill_last) coinc++;
        if (prev_hs) back2back++;
        prev_hs = 1'b1;
      end else prev_hs = 1'b0;
      if (fill_last) out_m--;
      if (out_m > out_peak) out_peak = out_m;
      if (fill_beat) lvl++;
      if (pix_pop && lvl > 0 && !(fill_beat && lvl == 1)) lvl--;
      else if (pix_pop && fill_beat && lvl == 1) lvl = lvl; // beat arrived on empty FIFO: no pop
    end
  end

  function automatic int exp_beats(input int b);
    int n = (b + 7) / 8;
    return (n == 0) ? 1 : n;
  endfunction

  function automatic int clampi(input int v, input int lo, input int hi);
    return (v < lo) ? lo : ((v > hi) ? hi : v);
  endfunction

  task automatic cmp_frame(input string tag, input int base, input int bytes, input int pitch,
                           input int lm1, input int blen_raw);
    int blen = clampi(blen_raw, 1, 16);
    int lines = clampi(lm1, 0, 2047) + 1;
    int k = 0;
    bit bad = 0;
    longint ba = 0, ea = 0;
    for (int l = 0; l < lines; l++) begin
      int a = base + l * pitch;
      int rem = exp_beats(bytes);
      while (rem > 0) begin
        int b = (rem < blen) ? rem : blen;
        if (!bad && k < log_n && (log_addr[k] !== 32'(a) || log_beats[k] != b)) begin
          bad = 1; ba = {log_addr[k], 8'(log_beats[k])}; ea = {32'(a), 8'(b)};
        end
        a += b * 8; rem -= b; k++;
      end
    end
    check(log_n == k, {tag, " request count"}, log_n, k);
    check(!bad, {tag, " request addr/beats"}, ba, ea);
  endtask

  task automatic setup(input int base, input int bytes, input int pitch, input int lm1,
                       input int blen, input int mo);
    cfg_base = 32'(base); cfg_line_bytes = 16'(bytes); cfg_pitch = 16'(pitch);
    cfg_lines_m1 = 12'(lm1); cfg_burst_len = 5'(blen); cfg_max_out = 4'(mo);
  endtask

  task automatic pulse();
    @(negedge clk); frame_start = 1'b1;
    @(negedge clk); frame_start = 1'b0;
  endtask

  task automatic finish_frame();
    while (frame_busy) @(negedge clk);
    while (pq.size() != 0) @(negedge clk);
    repeat (4) @(negedge clk);
  endtask

  task automatic drain();
    resp_on = 1; pop_on = 1; act_on = 0;
    while (pq.size() != 0) @(negedge clk);
    repeat (80) @(negedge clk);
    log_n = 0; out_peak = 0; coinc = 0; back2back = 0; out_m = 0;
  endtask

  task automatic t_reset();
    check(req_valid === 1'b0, "R1 req_valid", req_valid, 0);
    check(frame_busy === 1'b0, "R1 frame_busy", frame_busy, 0);
    check(underrun === 1'b0, "R1 underrun", underrun, 0);
  endtask

  task automatic t_basic();
    drain();
    setup(32'h1000, 200, 256, 2, 16, 4);
    pulse();
    finish_frame();
    cmp_frame("R2 R3 basic frame", 32'h1000, 200, 256, 2, 16);
    begin
      bit seen = 0;
      for (int i = 0; i < 10; i++) begin
        @(negedge clk);
        if (req_valid !== 1'b0) seen = 1;
      end
      check(frame_busy === 1'b0 && !seen, "R8 idle after frame", {frame_busy, seen}, 0);
    end
  endtask

  task automatic t_split();
    drain(); setup(32'h2000, 20, 64, 1, 0, 4); pulse(); finish_frame();
    cmp_frame("R4 burst 0 used as 1", 32'h2000, 20, 64, 1, 0);
    drain(); setup(32'h3000, 300, 512, 0, 31, 4); pulse(); finish_frame();
    cmp_frame("R4 burst 31 used as 16", 32'h3000, 300, 512, 0, 31);
    drain(); setup(32'h4000, 0, 16, 2, 4, 4); pulse(); finish_frame();
    cmp_frame("R3 zero-byte line", 32'h4000, 0, 16, 2, 4);
  endtask

  task automatic t_outstanding();
    drain(); resp_on = 0;
    setup(32'h5000, 64, 64, 3, 4, 2); pulse();
    repeat (20) @(negedge clk);
    check(log_n == 2, "R6 held at limit 2", log_n, 2);
    check(req_valid === 1'b0, "R6 no offer at limit", req_valid, 0);
    resp_on = 1; finish_frame();
    cmp_frame("R6 limited frame", 32'h5000, 64, 64, 3, 4);
    check(out_peak <= 2, "R6 peak outstanding", out_peak, 2);
  endtask

  task automatic t_coinc();
    drain(); setup(32'h6000, 64, 128, 1, 1, 2); pulse(); finish_frame();
    cmp_frame("R6 coincident frame", 32'h6000, 64, 128, 1, 1);
    check(coinc > 0, "R6 accept with last seen", coinc, 1);
    check(out_peak <= 2, "R6 peak with coincidence", out_peak, 2);
    drain(); setup(32'h6800, 64, 64, 0, 1, 0); pulse(); finish_frame();
    check(out_peak == 1, "R6 limit 0 used as 1", out_peak, 1);
    check(back2back == 0, "R6 limit 1 no back-to-back", back2back, 0);
    drain(); resp_on = 0; setup(32'h7000, 160, 160, 0, 1, 15); pulse();
    repeat (30) @(negedge clk);
    check(log_n == 8, "R6 limit 15 used as 8", log_n, 8);
    resp_on = 1; finish_frame();
  endtask

  task automatic t_room();
    drain(); pop_on = 0;
    setup(32'h8000, 1024, 1024, 0, 16, 8); pulse();
    repeat (60) @(negedge clk);
    check(log_n == 4, "R7 stop when FIFO promised full", log_n, 4);
    pop_on = 1; finish_frame();
    cmp_frame("R7 frame after room frees", 32'h8000, 1024, 1024, 0, 16);
  endtask

  task automatic t_underrun();
    drain(); under_bad = 0;
    under_seen = 0; pop_on = 1; act_on = 1;
    repeat (3) @(negedge clk);
    act_on = 0;
    repeat (3) @(negedge clk);
    check(under_seen == 3, "R9 three empty active pops", under_seen, 3);
    under_seen = 0;
    repeat (5) @(negedge clk);
    check(under_seen == 0, "R9 inactive pops ignored", under_seen, 0);
    act_on = 1;
    setup(32'h9000, 256, 256, 3, 8, 3); pulse(); finish_frame();
    act_on = 0; repeat (3) @(negedge clk);
    check(under_bad == 0, "R9 flag matches level model", under_bad, 0);
  endtask

  task automatic t_restart();
    drain(); req_ready = 0; resp_on = 0;
    setup(32'hA000, 64, 128, 3, 16, 8); pulse();
    repeat (2) @(negedge clk);
    check(req_valid === 1'b1 && req_addr === 32'hA000, "R2 first addr", req_addr, 32'hA000);
    repeat (2) @(negedge clk);
    check(req_valid === 1'b1 && req_addr === 32'hA000 && req_beats === 5'd8,
          "R10 stalled request stable", {req_addr, 3'b0, req_beats}, {32'hA000, 8'd8});
    cfg_base = 32'hC000; pulse();
    check(req_addr === 32'hC000, "R2 restart base", req_addr, 32'hC000);
    req_ready = 1; resp_on = 1; finish_frame();
    cmp_frame("R2 restarted frame", 32'hC000, 64, 128, 3, 16);
  endtask

  task automatic t_lines();
    drain(); setup(0, 8, 8, 4095, 16, 8); pulse(); finish_frame();
    cmp_frame("R5 line count capped", 0, 8, 8, 4095, 16);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    t_basic();
    t_split();
    t_outstanding();
    t_coinc();
    t_room();
    t_underrun();
    t_restart();
    t_lines();
    if (!done) begin
      done = 1'b1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++; fails++;
      $display("FAIL watchdog expired actual=hung expected=finished");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

endmodule